// File: doc/BRIEF.md
# Single-Wire Bus Slave Controller

This block is the slave side of a serial bus that runs over one open-drain line. A pull-up holds the line high when it is idle. Any device on the line may pull it low, so simultaneous drivers combine as a wired-AND. The controller samples the line with the system clock through a two-stage synchronizer. When the master holds the line low long enough, the controller treats it as a reset and answers with a presence pulse. It then accepts an 8-bit command, one time slot per bit.

When the command is the identity read (0x33), the controller returns a 64-bit identity word, one bit per master-started slot. The word is made of a family byte, a 48-bit serial number and a CRC byte. The CRC byte is computed at elaboration from the other two fields. Any other command is flagged as unsupported, and the controller then waits for the next reset. A speed input switches every timing window between normal and overdrive values. All windows are counted in clock cycles, using a cycles-per-microsecond parameter.

Top module: `swire_slave`

## Requirements
- R1: After rst_n is released, pull_o, cmd_valid_o and unsupported_o are 0 and cmd_o is 0x00.
- R2: A low level shorter than the reset threshold is not a reset and produces no presence pulse. The threshold is 120 us at normal speed and 16 us in overdrive. A longer low level, once released, counts as a reset.
- R3: After a reset is released, the slave waits about 30 us (3 us in overdrive) and then pulls the line low for about 120 us (12 us in overdrive). This is the presence pulse.
- R4: After the presence pulse, each master falling edge opens a write slot. The line is sampled about 30 us (3 us in overdrive) after the edge: low means 0 and high means 1. Bits arrive least significant first. The 8th bit updates cmd_o and pulses cmd_valid_o for one cycle.
- R5: After command 0x33, each master falling edge opens a read slot. Bit k of the identity word is sent in slot k, with bit 0 first. Bits 7:0 are the family byte, bits 55:8 the serial number and bits 63:56 the CRC byte. For a 0 bit the slave pulls the line low for about 30 us (3 us in overdrive). For a 1 bit it leaves the line released.
- R6: The CRC byte is the reflected CRC-8 with polynomial x^8+x^5+x^4+1 (shift constant 0x8C, initial value 0). It is computed over the 56 bits that precede it, least significant bit first. The CRC over all 64 bits is therefore 0.
- R7: A command other than 0x33 sets unsupported_o. The slave then drives no slot and decodes no further command until the next reset, which clears unsupported_o.
- R8: A reset in the middle of an identity read abandons the read. A presence pulse follows, and a new command is then accepted and served from bit 0.
- R9: Before the first reset after rst_n, slots are ignored: the slave produces no command and no pull.
- R10: When overdrive_i is 1, the overdrive timing values are used for reset detection, presence, write sampling and the read-0 hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Sampled level of the bus line |
| overdrive_i | input | 1 | 1 selects overdrive timing, 0 selects normal timing |
| pull_o | output | 1 | 1 pulls the bus line low (open-drain enable) |
| cmd_o | output | 8 | Last received command byte |
| cmd_valid_o | output | 1 | One-cycle pulse when cmd_o is updated |
| unsupported_o | output | 1 | Last command was not 0x33; stays set until the next reset |

## Verification
Two functions can act on the same line edge: the reset detector and the slot engine. The master's falling edge that starts a long reset pulse also opens a read slot. The reset detector's counter runs while the slot engine may itself be pulling the line low for a 0 bit. The bench provokes this by sending a 480 us low partway through an identity read. It judges the outcome from the presence pulse timing that follows, and from a complete 64-bit read after a fresh 0x33 command, which must start again from bit 0.

// File: rtl/swire_slave.sv
`timescale 1ns/1ps
module swire_slave #(
  parameter int          CYC_PER_US = 4,
  parameter logic [7:0]  FAMILY     = 8'h2A,
  parameter logic [47:0] SERIAL     = 48'h5EC0_9137_A40B,
  parameter int          N_RST_US   = 120,
  parameter int          O_RST_US   = 16,
  parameter int          N_SMP_US   = 30,
  parameter int          O_SMP_US   = 3,
  parameter int          N_PWAIT_US = 30,
  parameter int          O_PWAIT_US = 3,
  parameter int          N_PLEN_US  = 120,
  parameter int          O_PLEN_US  = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_i,
  input  logic       overdrive_i,
  output logic       pull_o,
  output logic [7:0] cmd_o,
  output logic       cmd_valid_o,
  output logic       unsupported_o
);

  function automatic logic [7:0] crc_of(input logic [55:0] d);
    logic [7:0] c;
    c = '0;
    for (int i = 0; i < 56; i++) begin
      logic fb;
      fb = c[0] ^ d[i];
      c  = {1'b0, c[7:1]} ^ (fb ? 8'h8C : 8'h00);
    end
    return c;
  endfunction

  localparam int MAXW = (N_RST_US > N_PLEN_US ? N_RST_US : N_PLEN_US) * CYC_PER_US;
  localparam int CW   = $clog2(MAXW + 2) + 1;
  localparam logic [63:0] ID_WORD = {crc_of({SERIAL, FAMILY}), SERIAL, FAMILY};
  localparam logic [7:0]  CMD_ID  = 8'h33;

  typedef enum logic [2:0] {S_WRST, S_PWAIT, S_PDRV, S_CMD, S_READ} st_t;

  st_t           st;
  logic [2:0]    sy;
  logic [CW-1:0] lcnt, tcnt;
  logic          armed, slot_act;
  logic [6:0]    bitcnt;
  logic [7:0]    shreg;

  wire s_now   = sy[1];
  wire fall    = sy[2] & ~sy[1];
  wire rst_evt = armed & s_now;

  wire [CW-1:0] t_rst = overdrive_i ? CW'(O_RST_US * CYC_PER_US)   : CW'(N_RST_US * CYC_PER_US);
  wire [CW-1:0] t_smp = overdrive_i ? CW'(O_SMP_US * CYC_PER_US)   : CW'(N_SMP_US * CYC_PER_US);
  wire [CW-1:0] t_pw  = overdrive_i ? CW'(O_PWAIT_US * CYC_PER_US) : CW'(N_PWAIT_US * CYC_PER_US);
  wire [CW-1:0] t_pl  = overdrive_i ? CW'(O_PLEN_US * CYC_PER_US)  : CW'(N_PLEN_US * CYC_PER_US);

  wire [7:0] nxt_byte = {s_now, shreg[7:1]};

  assign pull_o = (st == S_PDRV) | ((st == S_READ) & slot_act & ~ID_WORD[bitcnt[5:0]]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sy <= 3'b111;
    else        sy <= {sy[1:0], line_i};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lcnt  <= '0;
      armed <= 1'b0;
    end else begin
      if (!s_now && !pull_o) lcnt <= (lcnt == '1) ? lcnt : lcnt + 1'b1;
      else                   lcnt <= '0;
      armed <= s_now ? 1'b0 : (armed | (lcnt > t_rst));
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st            <= S_WRST;
      tcnt          <= '0;
      slot_act      <= 1'b0;
      bitcnt        <= '0;
      shreg         <= '0;
      cmd_o         <= '0;
      cmd_valid_o   <= 1'b0;
      unsupported_o <= 1'b0;
    end else begin
      cmd_valid_o <= 1'b0;
      if (rst_evt) begin
        st            <= S_PWAIT;
        tcnt          <= '0;
        slot_act      <= 1'b0;
        bitcnt        <= '0;
        unsupported_o <= 1'b0;
      end else begin
        case (st)
          S_PWAIT:
            if (tcnt >= t_pw - 1'b1) begin
              st   <= S_PDRV;
              tcnt <= '0;
            end else tcnt <= tcnt + 1'b1;
          S_PDRV:
            if (tcnt >= t_pl - 1'b1) begin
              st       <= S_CMD;
              tcnt     <= '0;
              bitcnt   <= '0;
              slot_act <= 1'b0;
            end else tcnt <= tcnt + 1'b1;
          S_CMD:
            if (!slot_act) begin
              if (fall) begin
                slot_act <= 1'b1;
                tcnt     <= '0;
              end
            end else if (tcnt >= t_smp - 1'b1) begin
              slot_act <= 1'b0;
              shreg    <= nxt_byte;
              if (bitcnt == 7'd7) begin
                cmd_o       <= nxt_byte;
                cmd_valid_o <= 1'b1;
                bitcnt      <= '0;
                if (nxt_byte == CMD_ID) st <= S_READ;
                else begin
                  unsupported_o <= 1'b1;
                  st            <= S_WRST;
                end
              end else bitcnt <= bitcnt + 1'b1;
            end else tcnt <= tcnt + 1'b1;
          S_READ:
            if (!slot_act) begin
              if (fall) begin
                slot_act <= 1'b1;
                tcnt     <= '0;
              end
            end else if (tcnt >= t_smp - 1'b1) begin
              slot_act <= 1'b0;
              if (bitcnt == 7'd63) st <= S_WRST;
              else                 bitcnt <= bitcnt + 1'b1;
            end else tcnt <= tcnt + 1'b1;
          default: ;
        endcase
      end
    end

  logic [CW-1:0] plcnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) plcnt <= '0;
    else        plcnt <= pull_o ? plcnt + 1'b1 : '0;

  AST_PULL_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    pull_o |-> (plcnt < CW'(MAXW + 1))); // R3
  AST_CMDV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |=> !cmd_valid_o); // R4
  AST_READ_AFTER_ID: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_READ && $past(st) == S_CMD) |-> (cmd_o == CMD_ID)); // R5
  AST_UNSUP_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unsupported_o) |-> (cmd_o != CMD_ID && cmd_valid_o)); // R7
  AST_UNSUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    unsupported_o |-> !pull_o); // R7

endmodule

// File: tb/swire_slave_bench.sv
`timescale 1ns/1ps
module swire_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CPU = 4;
  localparam logic [7:0]  FAM = 8'h2A;
  localparam logic [47:0] SER = 48'h5EC0_9137_A40B;

  logic clk = 0, rst_n = 0, od = 0, m_lo = 0;
  logic pull_o, cmd_valid_o, unsupported_o;
  logic [7:0] cmd_o;
  wire line = ~(m_lo | pull_o);

  swire_slave #(.CYC_PER_US(CPU), .FAMILY(FAM), .SERIAL(SER)) u_swire_slave (
    .clk(clk), .rst_n(rst_n), .line_i(line), .overdrive_i(od),
    .pull_o(pull_o), .cmd_o(cmd_o), .cmd_valid_o(cmd_valid_o), .unsupported_o(unsupported_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cv_cnt = 0, pull_cnt = 0;
  bit done = 0;
  bit exp_q[$];
  bit got_q[$];
  string tag_q[$];

  always @(posedge clk) begin
    if (cmd_valid_o) cv_cnt <= cv_cnt + 1;
    if (pull_o) pull_cnt <= pull_cnt + 1;
  end

  function automatic logic [7:0] ref_crc(input logic [63:0] v, input int nbytes);
    logic [7:0] c = 0;
    for (int b = 0; b < nbytes; b++) begin
      logic [7:0] by = v[b*8 +: 8];
      for (int k = 0; k < 8; k++) begin
        logic mix = c[0] ^ by[0];
        c = c >> 1;
        if (mix) c = c ^ 8'h8C;
        by = by >> 1;
      end
    end
    return c;
  endfunction

  localparam logic [63:0] EXP_ID = {ref_crc({8'h00, SER, FAM}, 7), SER, FAM};

  task automatic check(string req, int got, int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wc(int c); repeat (c) @(negedge clk); endtask

  task automatic low_for(int cyc);
    m_lo = 1; wc(cyc); m_lo = 0;
  endtask

  task automatic write_bit(bit b);
    int lo = od ? (b ? 4 : 28) : (b ? 24 : 240);
    int tot = od ? 40 : 300;
    low_for(lo); wc(tot - lo);
  endtask

  task automatic write_byte(logic [7:0] v);
    for (int i = 0; i < 8; i++) write_bit(v[i]);
  endtask

  task automatic read_bit(output bit b);
    low_for(4);
    wc(od ? 6 : 56);
    b = line;
    wc(od ? 30 : 240);
  endtask

  task automatic reset_and_presence(string req);
    low_for(od ? 20*CPU : 480*CPU);
    wc(od ? 2*CPU : 10*CPU);
    check({req, " before presence"}, pull_o, 0);
    wc(od ? 6*CPU : 50*CPU);
    check({req, " presence active"}, pull_o, 1);
    wc(od ? 12*CPU : 140*CPU);
    check({req, " presence ended"}, pull_o, 0);
    wc(od ? 5*CPU : 20*CPU);
  endtask

  task automatic read_id(int n, string req, output logic [63:0] rx);
    rx = '0;
    for (int i = 0; i < n; i++) begin
      bit b;
      exp_q.push_back(EXP_ID[i]);
      tag_q.push_back(req);
      read_bit(b);
      rx[i] = b;
      got_q.push_back(b);
    end
  endtask

  initial begin
    forever begin
      bit g, e;
      string t;
      wait (got_q.size() != 0);
      g = got_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check({t, " id bit"}, g, e);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] rx;
    bit b;
    int pc, cv;
    wc(5); rst_n = 1; wc(3);
    // R1
    check("R1 pull", pull_o, 0);
    check("R1 cmd_valid", cmd_valid_o, 0);
    check("R1 unsupported", unsupported_o, 0);
    check("R1 cmd", cmd_o, 0);

    // R9: slots before any reset
    write_byte(8'h33);
    read_bit(b);
    check("R9 read bit released", b, 1);
    check("R9 no command", cv_cnt, 0);
    check("R9 no pull", pull_cnt, 0);

    // R2: short low is not a reset
    low_for(100*CPU);
    wc(300*CPU);
    check("R2 short low no presence", pull_cnt, 0);

    // R2, R3: real reset
    reset_and_presence("R2 R3");

    // R4: command reception
    write_byte(8'h33);
    check("R4 cmd", cmd_o, 8'h33);
    check("R4 one valid pulse", cv_cnt, 1);
    check("R4 not unsupported", unsupported_o, 0);

    // R5, R6: full identity read
    read_id(64, "R5", rx);
    check("R6 crc residue", ref_crc(rx, 8), 0);
    check("R6 crc byte", rx[63:56], ref_crc({8'h00, rx[55:0]}, 7));

    // R8: reset in the middle of a read
    reset_and_presence("R8 first");
    write_byte(8'h33);
    read_id(10, "R8 partial", rx);
    reset_and_presence("R8 abort");
    write_byte(8'h33);
    check("R8 command again", cv_cnt, 3);
    read_id(64, "R8 restart", rx);

    // R7: unsupported command
    reset_and_presence("R7");
    write_byte(8'hF0);
    check("R7 cmd", cmd_o, 8'hF0);
    check("R7 flag", unsupported_o, 1);
    pc = pull_cnt; cv = cv_cnt;
    read_bit(b);
    check("R7 slot ignored", b, 1);
    write_byte(8'h33);
    check("R7 no decode", cv_cnt, cv);
    check("R7 no pull", pull_cnt, pc);
    check("R7 flag held", unsupported_o, 1);
    reset_and_presence("R7 clear");
    check("R7 flag cleared", unsupported_o, 0);

    // R10: overdrive timing
    od = 1;
    wc(10*CPU);
    pc = pull_cnt;
    low_for(12*CPU);
    wc(40*CPU);
    check("R10 R2 short overdrive low", pull_cnt, pc);
    reset_and_presence("R10");
    write_byte(8'h33);
    check("R10 cmd", cmd_o, 8'h33);
    read_id(64, "R10", rx);
    check("R10 crc residue", ref_crc(rx, 8), 0);

    while (got_q.size() != 0) #1;
    wc(2);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule